// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

This block sits between a host register bus and a byte-wide transmit path. It holds two frame buffers, called ping and pong, in one 32-bit word-addressed space. Each buffer has its own length register and its own status register. The host writes the frame words into a buffer, writes the byte count and then sets the busy flag. The controller streams the frame out one byte per accepted beat and drops busy once the last byte has been taken.

The status register has a second use. If the busy flag is set together with the program flag, the controller sends no frame. It copies the first six bytes of the buffer into its station-address register instead. Writing zero to a status register cancels whatever that buffer is doing. The pong buffer is present only when the `PONG_EN` parameter is set; otherwise its registers accept no writes and read as zero.

Top module: `tx_dual_buf`

## Requirements
- R1: After reset, every status and length register reads 0, `tx_valid` and `irq` are low, and `station_addr` is 0.
- R2: The word addresses hold the register map (byte offset / 4). Ping data starts at byte 0x000, ping length is at 0x7F4 and ping status is at 0x7FC. Pong data starts at 0x800, pong length is at 0xFF4 and pong status is at 0xFFC. Length reads back in bits 15:0, with bits 31:16 reading 0. Status reads back busy in bit 0, program in bit 1 and interrupt enable in bit 3, with all other bits 0. Setting bit 3 alone does not launch the buffer.
- R3: Writing status with bit 0 = 1 and bit 1 = 0 sends exactly `length` bytes from that buffer. Within each word the byte in bits 7:0 goes first and the byte in bits 31:24 goes last. A final partial word sends only the bytes that remain in the count. `tx_last` is high on the final byte only.
- R4: A byte is consumed only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` holds and busy stays set. Busy reads 0 once the final byte has been accepted.
- R5: Writing status with bits 0 and 1 both set stores buffer byte k in `station_addr[8k+7:8k]` for k = 0 to 5. No byte is sent, and bits 0 and 1 both read 0 afterwards.
- R6: Bit 3 of a status register survives the completion of that buffer. When busy clears on completion and bit 3 is set, `irq` is high for exactly one cycle. When bit 3 is clear, `irq` stays low.
- R7: Only one frame is on the output at a time. A buffer launched while the other is sending waits, and the two frames come out in the order they were launched.
- R8: Writing 0 to a busy buffer's status register stops its output, with `tx_valid` low from the next cycle. Busy reads 0 and no `irq` is raised.
- R9: A transmit launched with length 0 completes with no byte sent and still raises `irq` if bit 3 is set.
- R10: With `PONG_EN` = 0, writes to the pong length and status are ignored, both read 0, and no frame is sent for the pong buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_addr | input | AW | Host word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | AW | Host word read address |
| rd_data | output | 32 | Length or status value; other addresses read 0 |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| station_addr | output | 48 | Loaded station address |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A table of frames is sent with lengths 1, 4, 7, 8, 13 and 64, alternating between the two buffers and each with its own byte pattern. Whole words and partial final words therefore expose errors in byte order, byte count and `tx_last`. A seeded pattern that differs per frame separates the ping data from the pong data, so a wrong buffer select shows up as wrong bytes. Directed cases then cover the corners: a frame held by `tx_ready` low, a pong frame queued behind a ping frame, an abort, a zero-length launch, an address load, and a second instance built without pong.

// File: rtl/tx_dual_buf.sv
module tx_dual_buf #(
  parameter int BUF_WORDS = 512,
  parameter bit PONG_EN = 1'b1,
  localparam int AW = $clog2(BUF_WORDS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic [47:0]   station_addr,
  output logic          irq
);
  localparam int OW = AW - 1;
  localparam logic [OW-1:0] LEN_OFF  = OW'(BUF_WORDS - 3);
  localparam logic [OW-1:0] STAT_OFF = OW'(BUF_WORDS - 1);

  logic [31:0] mem [2][BUF_WORDS];
  logic [15:0] len_q [2];
  logic [1:0]  busy_q, prog_q, ie_q;
  logic        run_q, cur_q, irq_q;
  logic [15:0] idx_q;
  logic [47:0] mac_q;

  wire          wsel    = wr_addr[AW-1];
  wire [OW-1:0] woff    = wr_addr[OW-1:0];
  wire          wbuf_ok = !wsel || PONG_EN;
  wire          len_wr  = wr_en && wbuf_ok && woff == LEN_OFF;
  wire          stat_wr = wr_en && wbuf_ok && woff == STAT_OFF;
  wire          mem_wr  = wr_en && wbuf_ok && woff < LEN_OFF;

  wire          pick     = !busy_q[0];
  wire          act_buf  = run_q ? cur_q : pick;
  wire          cur_prog = prog_q[cur_q];
  wire [15:0]   last_idx = cur_prog ? 16'd5 : len_q[cur_q] - 16'd1;
  wire [31:0]   cur_word = mem[cur_q][idx_q[OW+1:2]];
  wire [7:0]    cur_byte = cur_word[8*idx_q[1:0] +: 8];
  wire          step     = run_q && (cur_prog || tx_ready);
  wire          done     = step && idx_q == last_idx;
  wire          zfin     = !run_q && |busy_q && !prog_q[pick] && len_q[pick] == 16'd0;
  wire          fin      = done || zfin;

  assign tx_valid     = run_q && !cur_prog;
  assign tx_data      = cur_byte;
  assign tx_last      = tx_valid && idx_q == last_idx;
  assign station_addr = mac_q;
  assign irq          = irq_q;

  always_ff @(posedge clk) begin
    if (mem_wr) mem[wsel][woff] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      prog_q <= '0;
      ie_q   <= '0;
      len_q  <= '{default: '0};
      run_q  <= 1'b0;
      cur_q  <= 1'b0;
      idx_q  <= '0;
      mac_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fin && ie_q[act_buf] && !(stat_wr && wsel == act_buf);
      if (run_q) begin
        if (step) begin
          if (cur_prog) mac_q[8*idx_q[2:0] +: 8] <= cur_byte;
          idx_q <= idx_q + 16'd1;
        end
        if (done) begin
          run_q         <= 1'b0;
          busy_q[cur_q] <= 1'b0;
          prog_q[cur_q] <= 1'b0;
        end
      end else if (|busy_q) begin
        if (zfin) busy_q[pick] <= 1'b0;
        else begin
          run_q <= 1'b1;
          cur_q <= pick;
          idx_q <= '0;
        end
      end
      if (len_wr) len_q[wsel] <= wr_data[15:0];
      if (stat_wr) begin
        ie_q[wsel] <= wr_data[3];
        if (!wr_data[0]) begin
          busy_q[wsel] <= 1'b0;
          prog_q[wsel] <= 1'b0;
          if (act_buf == wsel) run_q <= 1'b0;
        end else if (!busy_q[wsel]) begin
          busy_q[wsel] <= 1'b1;
          prog_q[wsel] <= wr_data[1];
        end
      end
    end
  end

  wire          rsel = rd_addr[AW-1];
  wire [OW-1:0] roff = rd_addr[OW-1:0];

  always_comb begin
    rd_data = '0;
    if (!rsel || PONG_EN) begin
      if (roff == LEN_OFF)       rd_data = {16'h0, len_q[rsel]};
      else if (roff == STAT_OFF) rd_data = {28'h0, ie_q[rsel], 1'b0, prog_q[rsel], busy_q[rsel]};
    end
  end

  // R7
  one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q == 2'b11) |-> run_q);
  // R3
  valid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy_q[cur_q]);
  // R4
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_en) |=> (tx_valid && $stable(tx_data)));
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (($past(busy_q) & ~busy_q) != 2'b00));
  // R5
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q & ~busy_q) == 2'b00);
  // R10
  no_pong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !PONG_EN |-> !busy_q[1]);
endmodule

// File: tb/tx_dual_buf_test.sv
module tx_dual_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] PONG_BASE = 10'h200;
  localparam logic [AW-1:0] LEN_W  = 10'h1FD;
  localparam logic [AW-1:0] STAT_W = 10'h1FF;
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_01_10, 24'h01_04_22, 24'h00_07_35,
    24'h01_08_4A, 24'h00_0D_5B, 24'h01_40_6C };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic tx_ready = 1;
  logic [31:0] rd_data, np_rd_data;
  logic [7:0] tx_data, np_tx_data;
  logic tx_valid, tx_last, irq, np_tx_valid, np_tx_last, np_irq;
  logic [47:0] station_addr, np_station;

  int nchk = 0, nfail = 0, nirq = 0, ncap = 0;
  logic [7:0] cap [256];
  logic capl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_dual_buf uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .tx_data, .tx_valid, .tx_last, .tx_ready, .station_addr, .irq);

  tx_dual_buf #(.PONG_EN(1'b0)) uut_np (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data(np_rd_data), .tx_data(np_tx_data), .tx_valid(np_tx_valid), .tx_last(np_tx_last),
    .tx_ready(1'b1), .station_addr(np_station), .irq(np_irq));

  always @(negedge clk) begin
    if (irq) nirq++;
    if (tx_valid && tx_ready && ncap < 256) begin
      cap[ncap] = tx_data;
      capl[ncap] = tx_last;
      ncap++;
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return s + 8'(k * 7);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] nd);
    rd_addr = a; #1;
    d = rd_data; nd = np_rd_data;
  endtask

  task automatic send_frame(input logic b, input int len, input logic [7:0] seed, input logic [31:0] st);
    logic [AW-1:0] base = b ? PONG_BASE : '0;
    for (int w = 0; w < (len + 3) / 4; w++)
      host_wr(base + AW'(w), {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
    host_wr(base + LEN_W, 32'(len));
    host_wr(base + STAT_W, st);
  endtask

  task automatic wait_idle(input logic b);
    logic [31:0] d, nd;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd((b ? PONG_BASE : '0) + STAT_W, d, nd);
      if (!d[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_frame(input string req, input int len, input logic [7:0] seed);
    int bad = -1, lastbad = -1;
    chk({req, " byte count"}, 64'(ncap), 64'(len));
    for (int k = 0; k < len && k < ncap; k++) begin
      if (bad < 0 && cap[k] !== pat(seed, k)) bad = k;
      if (lastbad < 0 && capl[k] !== (k == len - 1)) lastbad = k;
    end
    chk({req, " bytes"}, (bad < 0) ? 64'(0) : 64'(cap[bad]), (bad < 0) ? 64'(0) : 64'(pat(seed, bad)));
    chk({req, " last flag index"}, 64'(lastbad), 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d, nd;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(STAT_W, d, nd);             chk("R1 ping status", d, 0);
    rd(LEN_W, d, nd);              chk("R1 ping length", d, 0);
    rd(PONG_BASE + STAT_W, d, nd); chk("R1 pong status", d, 0);
    chk("R1 outputs", {tx_valid, irq, station_addr}, 0);

    // R2 register readback
    host_wr(PONG_BASE + LEN_W, 32'hABCD1234);
    @(negedge clk); rd(PONG_BASE + LEN_W, d, nd); chk("R2 pong length", d, 32'h1234);
    host_wr(PONG_BASE + STAT_W, 32'h8);
    repeat (3) @(negedge clk); rd(PONG_BASE + STAT_W, d, nd); chk("R2 pong status ie only", d, 32'h8);
    chk("R2 no launch", tx_valid, 0);

    // R3 vector table
    for (int v = 0; v < NV; v++) begin
      ncap = 0;
      send_frame(VEC[v][16], int'(VEC[v][15:8]), VEC[v][7:0], 32'h1);
      wait_idle(VEC[v][16]);
      chk_frame("R3 vector", int'(VEC[v][15:8]), VEC[v][7:0]);
      rd((VEC[v][16] ? PONG_BASE : '0) + STAT_W, d, nd); chk("R3 status idle", d, 0);
    end

    // R4 backpressure
    @(posedge clk); #1; tx_ready = 0; ncap = 0;
    send_frame(0, 6, 8'h40, 32'h1);
    repeat (4) @(negedge clk);
    chk("R4 held valid", tx_valid, 1);
    chk("R4 held byte", tx_data, pat(8'h40, 0));
    rd(STAT_W, d, nd); chk("R4 busy while held", d[0], 1);
    @(posedge clk); #1; tx_ready = 1;
    wait_idle(0);
    chk_frame("R4 after release", 6, 8'h40);

    // R5 station address load
    ncap = 0;
    host_wr(0, 32'h44332211);
    host_wr(1, 32'h00006655);
    host_wr(STAT_W, 32'h3);
    wait_idle(0);
    chk("R5 station", station_addr, 48'h665544332211);
    chk("R5 no bytes sent", ncap, 0);
    rd(STAT_W, d, nd); chk("R5 status cleared", d, 0);

    // R6 interrupt pulse and enable retention
    ncap = 0; n0 = nirq;
    send_frame(0, 5, 8'h77, 32'h9);
    wait_idle(0);
    chk("R6 one irq", nirq, n0 + 1);
    rd(STAT_W, d, nd); chk("R6 ie kept", d, 32'h8);
    n0 = nirq;
    send_frame(0, 3, 8'h19, 32'h1);
    wait_idle(0);
    chk("R6 no irq without ie", nirq, n0);

    // R7 launch order
    @(posedge clk); #1; tx_ready = 0; ncap = 0;
    send_frame(1, 5, 8'hA0, 32'h1);
    send_frame(0, 3, 8'h05, 32'h1);
    @(posedge clk); #1; tx_ready = 1;
    wait_idle(1); wait_idle(0);
    chk("R7 total bytes", ncap, 8);
    chk("R7 pong first", {cap[0], cap[4]}, {pat(8'hA0, 0), pat(8'hA0, 4)});
    chk("R7 ping second", {cap[5], cap[7], capl[4], capl[7]}, {pat(8'h05, 0), pat(8'h05, 2), 1'b1, 1'b1});

    // R8 abort
    @(posedge clk); #1; tx_ready = 0; ncap = 0;
    send_frame(0, 8, 8'h31, 32'h9);
    repeat (3) @(negedge clk);
    n0 = nirq;
    host_wr(STAT_W, 32'h0);
    @(negedge clk);
    chk("R8 valid dropped", tx_valid, 0);
    rd(STAT_W, d, nd); chk("R8 status idle", d, 0);
    @(posedge clk); #1; tx_ready = 1;
    repeat (5) @(negedge clk);
    chk("R8 no irq", nirq, n0);
    chk("R8 no bytes", ncap, 0);

    // R9 zero length
    ncap = 0; n0 = nirq;
    send_frame(1, 0, 8'h00, 32'h9);
    wait_idle(1);
    chk("R9 no bytes", ncap, 0);
    chk("R9 irq", nirq, n0 + 1);
    rd(PONG_BASE + STAT_W, d, nd); chk("R9 status", d, 32'h8);

    // R10 pong absent
    host_wr(PONG_BASE + LEN_W, 32'h55);
    @(negedge clk); rd(PONG_BASE + LEN_W, d, nd);
    chk("R10 pong length ignored", nd, 0);
    chk("R10 reference instance keeps it", d, 32'h55);
    host_wr(PONG_BASE + STAT_W, 32'h1);
    @(negedge clk); rd(PONG_BASE + STAT_W, d, nd);
    chk("R10 pong status ignored", nd, 0);
    n0 = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (np_tx_valid) n0++;
    end
    chk("R10 no pong frame", n0, 0);
    wait_idle(1);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule